// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between a CPU's 16-bit address bus and the storage on a plug-in cartridge. A CPU store into the lower half of the address space (0x0000–0x7FFF) does not reach memory. The block takes it as a control-register update, which can turn external RAM on or off, select a ROM bank or select a RAM bank. CPU accesses to the two program windows are translated at once, with no added cycle, into physical ROM and RAM addresses. The fixed window is 0x0000–0x3FFF and the switchable window is 0x4000–0x7FFF. Accesses to the external RAM window, 0xA000–0xBFFF, are translated the same way.

A parameter picks one of three mapper flavours, and each decodes its registers differently:
- **Wide:** the ROM bank number is 9 bits.
- **Clocked:** RAM-bank values 8 to 12 steer the RAM window onto one of five real-time-clock registers instead of RAM.
- **Nibble:** register writes are qualified by address bit 8, and only 4-bit data is kept in RAM.

ROM and RAM sizes are powers of two, given as address widths. The bank number is folded into those widths by dropping its high bits. Storage and clock counting live outside the block. The block drives their selects, address and write data, and returns their read data to the CPU. If a read of the RAM window reaches no device, the CPU sees 0xFF.

Top module: `cart_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and external RAM is disabled. A read of 0x4000 therefore maps to ROM byte 0x4000, and RAM-window reads return 0xFF with `ram_cs` low.
- R2: A write anywhere in 0x0000–0x1FFF enables the RAM window when data bits [3:0] equal 0xA. Any other value disables it.
- R3: In the wide flavour, a write to 0x2000–0x2FFF loads ROM bank bits [7:0], and a write to 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0. In the clocked flavour, a write anywhere in 0x2000–0x3FFF loads ROM bank bits [7:0].
- R4: In the wide and clocked flavours, a write to 0x4000–0x5FFF loads the RAM bank from data bits [3:0]. The nibble flavour ignores such writes, so its RAM bank stays 0.
- R5: `rom_addr` equals `cpu_addr[13:0]` when `cpu_addr[14]` is 0. Otherwise it equals `rom_bank*0x4000 + cpu_addr[13:0]`. In both cases the result is truncated to ROM_AW bits.
- R6: `ram_addr` equals `ram_bank*0x2000 + cpu_addr[12:0]`, truncated to RAM_AW bits. During a read or write in 0xA000–0xBFFF with RAM enabled and present, `ram_cs` is 1, and `ext_we` follows `cpu_wr`.
- R7: With RAM disabled, or with RAM absent (HAS_RAM=0), a RAM-window access raises neither select nor `ext_we`, and `cpu_rdata` is 0xFF. When a select is raised on a read, `cpu_rdata` equals `ext_rdata`.
- R8: In the clocked flavour with HAS_CLOCK=1, RAM-bank values 8–12 raise `clk_cs` instead of `ram_cs`, with `clk_idx` = bank−8. Bank values 13–15, and every bank value in the other flavours, go to RAM. `ram_cs` and `clk_cs` are never high together.
- R9: In the nibble flavour, an enable write is taken only when `cpu_addr[8]` is 0, and a ROM-bank write in 0x2000–0x3FFF only when `cpu_addr[8]` is 1. `ext_wdata[7:4]` is driven as 0.
- R10: Writes to 0x6000–0x7FFF and to 0x8000–0xFFFF change no register, and the registers hold whenever `cpu_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per store |
| cpu_rd | input | 1 | CPU read strobe |
| ext_rdata | input | 8 | Read data from the selected RAM or clock register |
| cpu_rdata | output | 8 | RAM-window read data returned to the CPU (0xFF when unselected) |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_cs | output | 1 | RAM select for the current access |
| clk_cs | output | 1 | Clock-register select for the current access |
| clk_idx | output | 3 | Clock register index 0–4 |
| ext_we | output | 1 | Write enable to the selected RAM or clock register |
| ext_wdata | output | 8 | Write data to RAM or clock register |

## Verification
Some properties are checked by assertions on every cycle:
- the enable register follows the low nibble of each accepted enable write;
- the registers hold across idle cycles and across writes above 0x5FFF;
- the nibble flavour ignores enable writes with address bit 8 set;
- the fixed ROM window passes the address through;
- RAM and clock selects never overlap;
- a disabled RAM window reads 0xFF.

Bank arithmetic cannot be read off a single cycle, so the bench scenarios cover it:
- truncation of wide bank numbers to small ROM and RAM sizes;
- the ninth ROM-bank bit;
- routing of bank values 8–12 to clock registers;
- 4-bit write data;
- the absent-RAM case.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  typedef enum logic [1:0] {
    MAP_WIDE    = 2'd0,
    MAP_CLOCKED = 2'd1,
    MAP_NIBBLE  = 2'd2
  } cmap_kind_e;

  localparam int ROM_BANK_W = 9;
  localparam int RAM_BANK_W = 4;
  localparam int ROM_PAGE_W = 14;
  localparam int RAM_PAGE_W = 13;

  localparam logic [RAM_BANK_W-1:0] CLK_BANK_LO = 4'd8;
  localparam logic [RAM_BANK_W-1:0] CLK_BANK_HI = 4'd12;

  typedef struct packed {
    logic                  ram_on;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
  } cmap_state_t;

endpackage

// File: rtl/cmap_ctrl_regs.sv
module cmap_ctrl_regs
  import cmap_pkg::*;
#(
  parameter cmap_kind_e KIND = MAP_WIDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [3:0]  a_hi,
  input  logic        a_b8,
  input  logic [7:0]  wdata,
  output cmap_state_t st
);

  localparam bit IS_WIDE = (KIND == MAP_WIDE);
  localparam bit IS_NIB  = (KIND == MAP_NIBBLE);

  logic en_hit, lo_hit, hi_hit, rb_hit;

  always_comb begin
    en_hit = wr && (a_hi[3:1] == 3'b000) && !(IS_NIB && a_b8);
    lo_hit = wr && (a_hi[3:1] == 3'b001) &&
             (IS_WIDE ? !a_hi[0] : (!IS_NIB || a_b8));
    hi_hit = wr && IS_WIDE && (a_hi == 4'h3);
    rb_hit = wr && !IS_NIB && (a_hi[3:1] == 3'b010);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.ram_on   <= 1'b0;
      st.rom_bank <= ROM_BANK_W'(1);
      st.ram_bank <= '0;
    end else begin
      if (en_hit) st.ram_on <= (wdata[3:0] == 4'hA);
      if (lo_hit) st.rom_bank[7:0] <= wdata;
      if (hi_hit) st.rom_bank[8] <= wdata[0];
      if (rb_hit) st.ram_bank <= wdata[RAM_BANK_W-1:0];
    end
  end

  AST_ENABLE_FOLLOWS_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && a_hi[3:1] == 3'b000 && !(IS_NIB && a_b8)) |=> (st.ram_on == ($past(wdata[3:0]) == 4'hA))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(st)); // R10
  AST_HIGH_WRITES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (a_hi[3] || a_hi[3:1] == 3'b011)) |=> $stable(st)); // R10
  AST_NIBBLE_ENABLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_NIB && wr && a_b8) |=> $stable(st.ram_on)); // R9

endmodule

// File: rtl/cmap_rom_map.sv
module cmap_rom_map
  import cmap_pkg::*;
#(
  parameter int ROM_AW = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [14:0]           addr,
  input  logic [ROM_BANK_W-1:0] bank,
  output logic [ROM_AW-1:0]     rom_addr
);

  localparam int FULL_W = ROM_BANK_W + ROM_PAGE_W;

  always_comb begin
    rom_addr = ROM_AW'(addr[14] ? {bank, addr[ROM_PAGE_W-1:0]}
                                : {{ROM_BANK_W{1'b0}}, addr[ROM_PAGE_W-1:0]});
  end

  generate
    if (ROM_AW < 15 || ROM_AW > FULL_W) begin : g_bad_width
      $error("ROM_AW out of range");
    end
  endgenerate

  AST_FIXED_WINDOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[14] |-> (rom_addr == ROM_AW'(addr[13:0]))); // R5

endmodule

// File: rtl/cmap_ram_map.sv
module cmap_ram_map
  import cmap_pkg::*;
#(
  parameter cmap_kind_e KIND      = MAP_WIDE,
  parameter bit         HAS_RAM   = 1'b1,
  parameter bit         HAS_CLOCK = 1'b0,
  parameter int         RAM_AW    = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [7:0]            wdata,
  input  logic [7:0]            ext_rdata,
  input  logic                  ram_on,
  input  logic [RAM_BANK_W-1:0] bank,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_cs,
  output logic                  clk_cs,
  output logic [2:0]            clk_idx,
  output logic                  ext_we,
  output logic [7:0]            ext_wdata,
  output logic [7:0]            cpu_rdata
);

  localparam int FULL_W = RAM_BANK_W + RAM_PAGE_W;

  logic in_win, access, to_clock;

  generate
    if (KIND == MAP_CLOCKED && HAS_CLOCK) begin : g_clock
      assign to_clock = (bank >= CLK_BANK_LO) && (bank <= CLK_BANK_HI);
    end else begin : g_noclock
      assign to_clock = 1'b0;
    end
    if (RAM_AW < 1 || RAM_AW > FULL_W) begin : g_bad_width
      $error("RAM_AW out of range");
    end
  endgenerate

  always_comb begin
    in_win    = (addr[15:13] == 3'b101);
    access    = in_win && (rd || wr) && ram_on;
    clk_cs    = access && to_clock;
    ram_cs    = access && !to_clock && HAS_RAM;
    clk_idx   = 3'(bank - CLK_BANK_LO);
    ram_addr  = RAM_AW'({bank, addr[RAM_PAGE_W-1:0]});
    ext_we    = wr && (ram_cs || clk_cs);
    ext_wdata = (KIND == MAP_NIBBLE) ? {4'h0, wdata[3:0]} : wdata;
    cpu_rdata = (rd && (ram_cs || clk_cs)) ? ext_rdata : 8'hFF;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_cs && clk_cs)); // R8
  AST_CLOSED_WINDOW_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && rd && !ram_on) |-> (cpu_rdata == 8'hFF && !ext_we)); // R7

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cmap_pkg::*;
#(
  parameter cmap_kind_e KIND      = MAP_WIDE,
  parameter int         ROM_AW    = 20,
  parameter int         RAM_AW    = 15,
  parameter bit         HAS_RAM   = 1'b1,
  parameter bit         HAS_CLOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        ext_rdata,
  output logic [7:0]        cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              clk_cs,
  output logic [2:0]        clk_idx,
  output logic              ext_we,
  output logic [7:0]        ext_wdata
);

  cmap_state_t st;

  cmap_ctrl_regs #(.KIND(KIND)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cpu_wr),
    .a_hi  (cpu_addr[15:12]),
    .a_b8  (cpu_addr[8]),
    .wdata (cpu_wdata),
    .st    (st)
  );

  cmap_rom_map #(.ROM_AW(ROM_AW)) u_rom (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (cpu_addr[14:0]),
    .bank     (st.rom_bank),
    .rom_addr (rom_addr)
  );

  cmap_ram_map #(
    .KIND      (KIND),
    .HAS_RAM   (HAS_RAM),
    .HAS_CLOCK (HAS_CLOCK),
    .RAM_AW    (RAM_AW)
  ) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (cpu_addr),
    .rd        (cpu_rd),
    .wr        (cpu_wr),
    .wdata     (cpu_wdata),
    .ext_rdata (ext_rdata),
    .ram_on    (st.ram_on),
    .bank      (st.ram_bank),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .clk_cs    (clk_cs),
    .clk_idx   (clk_idx),
    .ext_we    (ext_we),
    .ext_wdata (ext_wdata),
    .cpu_rdata (cpu_rdata)
  );

endmodule

// File: tb/tb_cart_mapper.sv
`timescale 1ns/1ps
module tb_cart_mapper;
  import cmap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  ext_rdata = 8'h5A;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // wide flavour, 8 MiB ROM, 32 KiB RAM
  logic [7:0] w_rd, w_wd; logic [22:0] w_rom; logic [14:0] w_ram;
  logic w_cs, w_ccs, w_we; logic [2:0] w_idx;
  cart_mapper #(.KIND(MAP_WIDE), .ROM_AW(23), .RAM_AW(15)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ext_rdata(ext_rdata), .cpu_rdata(w_rd),
    .rom_addr(w_rom), .ram_addr(w_ram), .ram_cs(w_cs), .clk_cs(w_ccs),
    .clk_idx(w_idx), .ext_we(w_we), .ext_wdata(w_wd));

  // clocked flavour with clock registers
  logic [7:0] c_rd, c_wd; logic [21:0] c_rom; logic [14:0] c_ram;
  logic c_cs, c_ccs, c_we; logic [2:0] c_idx;
  cart_mapper #(.KIND(MAP_CLOCKED), .ROM_AW(22), .RAM_AW(15), .HAS_CLOCK(1'b1)) dut_clk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ext_rdata(ext_rdata), .cpu_rdata(c_rd),
    .rom_addr(c_rom), .ram_addr(c_ram), .ram_cs(c_cs), .clk_cs(c_ccs),
    .clk_idx(c_idx), .ext_we(c_we), .ext_wdata(c_wd));

  // nibble flavour, 256 KiB ROM, 512 x 4-bit RAM
  logic [7:0] n_rd, n_wd; logic [17:0] n_rom; logic [8:0] n_ram;
  logic n_cs, n_ccs, n_we; logic [2:0] n_idx;
  cart_mapper #(.KIND(MAP_NIBBLE), .ROM_AW(18), .RAM_AW(9)) dut_nib (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ext_rdata(ext_rdata), .cpu_rdata(n_rd),
    .rom_addr(n_rom), .ram_addr(n_ram), .ram_cs(n_cs), .clk_cs(n_ccs),
    .clk_idx(n_idx), .ext_we(n_we), .ext_wdata(n_wd));

  // wide flavour without RAM
  logic [7:0] a_rd, a_wd; logic [19:0] a_rom; logic [14:0] a_ram;
  logic a_cs, a_ccs, a_we; logic [2:0] a_idx;
  cart_mapper #(.KIND(MAP_WIDE), .HAS_RAM(1'b0)) dut_noram (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ext_rdata(ext_rdata), .cpu_rdata(a_rd),
    .rom_addr(a_rom), .ram_addr(a_ram), .ram_cs(a_cs), .clk_cs(a_ccs),
    .clk_idx(a_idx), .ext_we(a_we), .ext_wdata(a_wd));

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [22:0] rom;
    logic        cs;
    logic [14:0] ram;
    logic [7:0]  rd;
  } row_t;

  localparam int NROWS = 20;
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 16'h4000, 8'h00, 23'h004000, 1'b0, 15'h0000, 8'hFF}, // R1 R5
    '{1'b0, 16'hA123, 8'h00, 23'h002123, 1'b0, 15'h0123, 8'hFF}, // R1 R7
    '{1'b1, 16'h0000, 8'h0A, 23'h0,      1'b0, 15'h0,    8'h00}, // enable
    '{1'b0, 16'hA123, 8'h00, 23'h002123, 1'b1, 15'h0123, 8'h5A}, // R2 R6 R7
    '{1'b1, 16'h2100, 8'h05, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b0, 16'h7FFF, 8'h00, 23'h017FFF, 1'b0, 15'h1FFF, 8'hFF}, // R3 R5
    '{1'b1, 16'h3000, 8'h01, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b0, 16'h4001, 8'h00, 23'h414001, 1'b0, 15'h0001, 8'hFF}, // R3 ninth bit
    '{1'b1, 16'h3FFF, 8'hFE, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b0, 16'h4001, 8'h00, 23'h014001, 1'b0, 15'h0001, 8'hFF}, // R3
    '{1'b1, 16'h4000, 8'h07, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b0, 16'hBFFF, 8'h00, 23'h003FFF, 1'b1, 15'h7FFF, 8'h5A}, // R4 R6 bank 7 folds to 3
    '{1'b1, 16'h6000, 8'h00, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b1, 16'h9000, 8'h00, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b0, 16'hA000, 8'h00, 23'h002000, 1'b1, 15'h6000, 8'h5A}, // R10 still enabled
    '{1'b0, 16'h4000, 8'h00, 23'h014000, 1'b0, 15'h6000, 8'hFF}, // R10 bank kept
    '{1'b1, 16'h1FFF, 8'h3B, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b0, 16'hA000, 8'h00, 23'h002000, 1'b0, 15'h6000, 8'hFF}, // R2 disabled
    '{1'b1, 16'h1000, 8'hFA, 23'h0,      1'b0, 15'h0,    8'h00},
    '{1'b0, 16'hA000, 8'h00, 23'h002000, 1'b1, 15'h6000, 8'h5A}  // R2 re-enabled
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // drive a bus access at the falling edge; outputs settle by #1
  task automatic bus_start(input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = !w;
    #1;
  endtask

  task automatic bus_end();
    @(posedge clk);
    #1;
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    bus_start(1'b1, a, d);
    bus_end();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      bus_start(TBL[i].wr, TBL[i].addr, TBL[i].data);
      if (!TBL[i].wr) begin
        chk($sformatf("row %0d rom_addr", i), 32'(w_rom), 32'(TBL[i].rom));
        chk($sformatf("row %0d ram_cs",   i), 32'(w_cs),  32'(TBL[i].cs));
        chk($sformatf("row %0d ram_addr", i), 32'(w_ram), 32'(TBL[i].ram));
        chk($sformatf("row %0d cpu_rdata",i), 32'(w_rd),  32'(TBL[i].rd));
      end
      bus_end();
    end

    // R1: reset returns to bank 1, RAM bank 0, disabled
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_start(1'b0, 16'h4000, 8'h00);
    chk("R1 rom after reset", 32'(w_rom), 32'h004000);
    bus_end();
    bus_start(1'b0, 16'hA000, 8'h00);
    chk("R1 ram_cs after reset", 32'(w_cs), 0);
    chk("R1 rdata after reset", 32'(w_rd), 32'hFF);
    chk("R1 ram bank after reset", 32'(w_ram), 0);
    bus_end();

    // R9: enable write with address bit 8 set is ignored by nibble flavour
    wr_reg(16'h0100, 8'h0A);
    bus_start(1'b0, 16'hA005, 8'h00);
    chk("R9 nibble enable gated cs", 32'(n_cs), 0);
    chk("R9 nibble enable gated rdata", 32'(n_rd), 32'hFF);
    chk("R2 wide enable at 0x0100", 32'(w_cs), 1);
    bus_end();

    // R9: ROM bank write with bit 8 clear is ignored; R3 clocked takes it
    wr_reg(16'h2000, 8'h03);
    bus_start(1'b0, 16'h4000, 8'h00);
    chk("R9 nibble bank gated", 32'(n_rom), 32'h04000);
    chk("R3 clocked bank low byte", 32'(c_rom), 32'h0C000);
    bus_end();

    // R9 R5: accepted with bit 8 set, folded to 4 bank bits
    wr_reg(16'h2100, 8'h13);
    bus_start(1'b0, 16'h4000, 8'h00);
    chk("R9 R5 nibble bank masked", 32'(n_rom), 32'h0C000);
    bus_end();

    // R4 R9 R6: nibble ignores RAM bank, truncates data
    wr_reg(16'h0000, 8'h0A);
    wr_reg(16'h4000, 8'h01);
    bus_start(1'b1, 16'hA1FF, 8'hC7);
    chk("R9 nibble we", 32'(n_we), 1);
    chk("R9 nibble wdata", 32'(n_wd), 32'h07);
    chk("R4 nibble ram bank ignored", 32'(n_ram), 32'h1FF);
    chk("R6 wide ram_addr on write", 32'(w_ram), 32'h21FF);
    chk("R6 wide wdata", 32'(w_wd), 32'hC7);
    chk("R6 wide we", 32'(w_we), 1);
    chk("R7 no-ram we", 32'(a_we), 0);
    bus_end();

    // R7: absent RAM gives 0xFF even when enabled
    bus_start(1'b0, 16'hA000, 8'h00);
    chk("R7 no-ram cs", 32'(a_cs), 0);
    chk("R7 no-ram rdata", 32'(a_rd), 32'hFF);
    bus_end();

    // R8: clock register routing
    wr_reg(16'h4000, 8'h08);
    bus_start(1'b0, 16'hA000, 8'h00);
    chk("R8 clk_cs at bank 8", 32'(c_ccs), 1);
    chk("R8 ram_cs off at bank 8", 32'(c_cs), 0);
    chk("R8 clk_idx 0", 32'(c_idx), 0);
    chk("R8 clock read data", 32'(c_rd), 32'h5A);
    chk("R8 wide bank 8 to RAM", 32'(w_cs), 1);
    chk("R8 wide no clk_cs", 32'(w_ccs), 0);
    bus_end();
    wr_reg(16'h4000, 8'h0C);
    bus_start(1'b1, 16'hA000, 8'h55);
    chk("R8 clk_idx 4", 32'(c_idx), 4);
    chk("R8 clock write enable", 32'(c_we), 1);
    bus_end();
    wr_reg(16'h4000, 8'h0D);
    bus_start(1'b0, 16'hB000, 8'h00);
    chk("R8 bank 13 clk_cs", 32'(c_ccs), 0);
    chk("R8 bank 13 ram_cs", 32'(c_cs), 1);
    chk("R8 bank 13 ram_addr", 32'(c_ram), 32'h3000);
    bus_end();

    // R3: clocked flavour keeps the full byte
    wr_reg(16'h3000, 8'h85);
    bus_start(1'b0, 16'h4000, 8'h00);
    chk("R3 clocked full byte", 32'(c_rom), 32'h214000);
    bus_end();

    // R9: disable with bit 8 set ignored by nibble; wide disables
    wr_reg(16'h0100, 8'h00);
    bus_start(1'b0, 16'hA000, 8'h00);
    chk("R9 nibble stays enabled", 32'(n_cs), 1);
    chk("R2 wide disabled", 32'(w_cs), 0);
    bus_end();

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule